// File: doc/BRIEF.md
# VLAN Slice Classifier and Validator

This block sits on the receive side of a packet pipeline, after the frame bytes have been parsed. Each frame arrives as a metadata word: the VLAN tag, the IP source address, both UDP ports, a flag that says the IP header carries options, a frame handle, and the inner packet offset and length. The low bits of the VLAN tag select one entry of a slice table. Each entry holds a code option, a slice data pointer and a slice data size. A host loads the table through a one-cycle write port.

A frame is forwarded only if its header is clean and the slice it maps to is enabled. A code option of zero disables a slice. A forwarded frame leaves as one record on the output ring. The record carries the slice number, the table entry, the tunnel identity and the frame position fields. Three running counters track forwarded frames, frames dropped for a disabled slice, and frames dropped for a malformed header.

The control is a three-state machine:
- ST_IDLE: the block waits for a frame. On the transition *accept* it starts the table read and moves to ST_LOOKUP.
- ST_LOOKUP: the table data is present and the block decides. The transition *discard* returns to ST_IDLE. The transition *pass* goes to ST_SEND.
- ST_SEND: the block offers the record and waits for the ring. The transition *handoff* returns to ST_IDLE.

Top module: `slice_classifier`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and all three counters read 0.
- R2: The table index is bits [11:0] of in_vlan. Bits [15:12] of in_vlan have no effect on the lookup or on out_slice.
- R3: A frame forwards when in_ip_opts is 0 and its entry has a nonzero code option. Its record then carries the following fields:
  - out_slice is the 12-bit index.
  - out_code, out_ptr and out_size come from the entry.
  - out_src_ip, out_sport, out_dport, out_handle, out_offset and out_length are copies of the accepted inputs.
  - out_valid rises after the second rising edge counted from the accepting edge.
- R4: A frame whose entry has code option 0 and in_ip_opts 0 produces no record. It increments cnt_drop_slice by 1 at the second edge after acceptance.
- R5: A frame with in_ip_opts 1 produces no record. It increments cnt_drop_bad by 1 at the second edge after acceptance, whatever its entry holds. It leaves cnt_drop_slice unchanged.
- R6: cnt_fwd increments by exactly 1 on each edge where out_valid and out_ready are both 1.
- R7: A host write to the same entry on the same edge that accepts a frame does not affect that frame, which sees the old entry. Later frames see the new entry.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and every record field stays stable.
- R9: in_ready is 1 only in ST_IDLE. It is 0 on the cycle after an accept and all the time a record is pending, so only one frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame metadata valid |
| in_ready | output | 1 | Block can accept a frame |
| in_vlan | input | 16 | VLAN tag |
| in_src_ip | input | 32 | IP source address |
| in_sport | input | 16 | UDP source port |
| in_dport | input | 16 | UDP destination port |
| in_ip_opts | input | 1 | IP header carries options |
| in_handle | input | 32 | Frame buffer handle |
| in_offset | input | 16 | Inner packet offset |
| in_length | input | 16 | Inner packet length |
| tbl_we | input | 1 | Host table write strobe |
| tbl_addr | input | 12 | Host write index |
| tbl_code | input | 4 | Code option written |
| tbl_ptr | input | 32 | Slice data pointer written |
| tbl_size | input | 16 | Slice data size written |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Ring accepts record |
| out_slice | output | 12 | Slice number |
| out_code | output | 4 | Code option |
| out_ptr | output | 32 | Slice data pointer |
| out_size | output | 16 | Slice data size |
| out_src_ip | output | 32 | Tunnel source address |
| out_sport | output | 16 | Tunnel source port |
| out_dport | output | 16 | Tunnel destination port |
| out_handle | output | 32 | Frame handle |
| out_offset | output | 16 | Inner packet offset |
| out_length | output | 16 | Inner packet length |
| cnt_fwd | output | 32 | Forwarded frame count |
| cnt_drop_slice | output | 32 | Disabled-slice drop count |
| cnt_drop_bad | output | 32 | Malformed-frame drop count |

## Verification
Each result is due a fixed number of edges after the accepting edge:
- in_ready falls right after that edge and out_valid is still low.
- One edge later, either out_valid is up or the matching drop counter has moved.
- cnt_fwd moves on the edge that completes the output handshake.

The driver samples at the falling edge after the accepting edge and again one falling edge later. It compares out_valid and the drop counters against its own table model at exactly those two points. The monitor checks each record at the quarter-period after a falling edge. It checks cnt_fwd one sample after the handshake it observed.

// File: rtl/slice_cls_pkg.sv
package slice_cls_pkg;

    localparam int CODE_W = 4;
    localparam int PTR_W  = 32;
    localparam int SIZE_W = 16;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;
    localparam int HND_W  = 32;
    localparam int OFS_W  = 16;

    localparam int NUM_CNT = 3;
    localparam int CNT_FWD = 0;
    localparam int CNT_SLC = 1;
    localparam int CNT_BAD = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PTR_W-1:0]  ptr;
        logic [SIZE_W-1:0] size;
    } slice_ent_t;

    typedef struct packed {
        logic [IP_W-1:0]   src_ip;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
        logic              ip_opts;
        logic [HND_W-1:0]  handle;
        logic [OFS_W-1:0]  offset;
        logic [OFS_W-1:0]  length;
    } frame_meta_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SEND
    } cls_state_e;

endpackage

// File: rtl/slice_tbl.sv
module slice_tbl
    import slice_cls_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  slice_ent_t       wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output slice_ent_t       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    slice_ent_t mem [DEPTH];

    // Read and write share an edge; the read returns the pre-write entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/slice_cnt.sv
module slice_cnt #(
    parameter int CNT_W = 32,
    parameter int N     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            inc,
    output logic [N-1:0][CNT_W-1:0] val
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val[i] <= '0;
            end else if (inc[i]) begin
                val[i] <= val[i] + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/slice_classifier.sv
module slice_classifier
    import slice_cls_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int VLAN_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VLAN_W-1:0] in_vlan,
    input  logic [IP_W-1:0]   in_src_ip,
    input  logic [PORT_W-1:0] in_sport,
    input  logic [PORT_W-1:0] in_dport,
    input  logic              in_ip_opts,
    input  logic [HND_W-1:0]  in_handle,
    input  logic [OFS_W-1:0]  in_offset,
    input  logic [OFS_W-1:0]  in_length,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [CODE_W-1:0] tbl_code,
    input  logic [PTR_W-1:0]  tbl_ptr,
    input  logic [SIZE_W-1:0] tbl_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_slice,
    output logic [CODE_W-1:0] out_code,
    output logic [PTR_W-1:0]  out_ptr,
    output logic [SIZE_W-1:0] out_size,
    output logic [IP_W-1:0]   out_src_ip,
    output logic [PORT_W-1:0] out_sport,
    output logic [PORT_W-1:0] out_dport,
    output logic [HND_W-1:0]  out_handle,
    output logic [OFS_W-1:0]  out_offset,
    output logic [OFS_W-1:0]  out_length,
    output logic [CNT_W-1:0]  cnt_fwd,
    output logic [CNT_W-1:0]  cnt_drop_slice,
    output logic [CNT_W-1:0]  cnt_drop_bad
);
    cls_state_e                    state_q;
    cls_state_e                    state_d;
    frame_meta_t                   meta_q;
    logic [IDX_W-1:0]              slice_q;
    slice_ent_t                    ent_rd;
    slice_ent_t                    ent_wr;
    logic                          accept;
    logic                          frame_bad;
    logic                          slice_off;
    logic [NUM_CNT-1:0]            cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic                          vlan_unused;

    assign vlan_unused = ^in_vlan[VLAN_W-1:IDX_W];
    assign accept      = in_valid && in_ready;
    assign ent_wr      = '{code: tbl_code, ptr: tbl_ptr, size: tbl_size};
    assign frame_bad   = meta_q.ip_opts;
    assign slice_off   = (ent_rd.code == '0);

    slice_tbl #(.IDX_W(IDX_W)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (ent_wr),
        .re    (accept),
        .raddr (in_vlan[IDX_W-1:0]),
        .rdata (ent_rd)
    );

    slice_cnt #(.CNT_W(CNT_W), .N(NUM_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .val   (cnt_val)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, pass, discard, handoff
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (frame_bad || slice_off) ? ST_IDLE : ST_SEND;
            ST_SEND:   if (out_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        cnt_inc   = '0;
        unique case (state_q)
            ST_IDLE:   in_ready = 1'b1;
            ST_LOOKUP: begin
                cnt_inc[CNT_BAD] = frame_bad;
                cnt_inc[CNT_SLC] = !frame_bad && slice_off;
            end
            ST_SEND: begin
                out_valid        = 1'b1;
                cnt_inc[CNT_FWD] = out_ready;
            end
            default: ;
        endcase
    end

    // Frame capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            slice_q <= '0;
        end else if (accept) begin
            meta_q  <= '{src_ip: in_src_ip, sport: in_sport, dport: in_dport,
                         ip_opts: in_ip_opts, handle: in_handle,
                         offset: in_offset, length: in_length};
            slice_q <= in_vlan[IDX_W-1:0];
        end
    end

    assign out_slice      = slice_q;
    assign out_code       = ent_rd.code;
    assign out_ptr        = ent_rd.ptr;
    assign out_size       = ent_rd.size;
    assign out_src_ip     = meta_q.src_ip;
    assign out_sport      = meta_q.sport;
    assign out_dport      = meta_q.dport;
    assign out_handle     = meta_q.handle;
    assign out_offset     = meta_q.offset;
    assign out_length     = meta_q.length;
    assign cnt_fwd        = cnt_val[CNT_FWD];
    assign cnt_drop_slice = cnt_val[CNT_SLC];
    assign cnt_drop_bad   = cnt_val[CNT_BAD];
endmodule

// File: rtl/slice_classifier_chk.sv
module slice_classifier_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [3:0]       out_code,
    input logic [31:0]      out_handle,
    input logic [31:0]      out_ptr,
    input logic [CNT_W-1:0] cnt_fwd,
    input logic [CNT_W-1:0] cnt_drop_slice,
    input logic [CNT_W-1:0] cnt_drop_bad
);
    AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_handle) && $stable(out_code) && $stable(out_ptr))); // R8

    AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R9

    AST_FWD_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code != 4'd0)); // R4

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (cnt_fwd == $past(cnt_fwd) + CNT_W'(1))); // R6

    AST_BAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_drop_bad != $past(cnt_drop_bad)) |->
            (cnt_drop_bad == $past(cnt_drop_bad) + CNT_W'(1) && $stable(cnt_drop_slice))); // R5

    AST_SLICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_drop_slice != $past(cnt_drop_slice)) |->
            (cnt_drop_slice == $past(cnt_drop_slice) + CNT_W'(1))); // R4
endmodule

bind slice_classifier slice_classifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_code       (out_code),
    .out_handle     (out_handle),
    .out_ptr        (out_ptr),
    .cnt_fwd        (cnt_fwd),
    .cnt_drop_slice (cnt_drop_slice),
    .cnt_drop_bad   (cnt_drop_bad)
);

// File: tb/slice_classifier_test.sv
module slice_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_vlan;
    logic [31:0] in_src_ip;
    logic [15:0] in_sport;
    logic [15:0] in_dport;
    logic        in_ip_opts;
    logic [31:0] in_handle;
    logic [15:0] in_offset;
    logic [15:0] in_length;
    logic        tbl_we;
    logic [11:0] tbl_addr;
    logic [3:0]  tbl_code;
    logic [31:0] tbl_ptr;
    logic [15:0] tbl_size;
    logic        out_valid;
    logic        out_ready;
    logic [11:0] out_slice;
    logic [3:0]  out_code;
    logic [31:0] out_ptr;
    logic [15:0] out_size;
    logic [31:0] out_src_ip;
    logic [15:0] out_sport;
    logic [15:0] out_dport;
    logic [31:0] out_handle;
    logic [15:0] out_offset;
    logic [15:0] out_length;
    logic [31:0] cnt_fwd;
    logic [31:0] cnt_drop_slice;
    logic [31:0] cnt_drop_bad;

    always #10 clk = ~clk;

    slice_classifier uut (.*);

    int checks = 0;
    int fails  = 0;
    int e_fwd = 0, e_dslice = 0, e_dbad = 0;
    logic [191:0] exp_q[$];
    string        tag_q[$];
    logic [51:0]  mdl [int];
    bit           fwd_pend = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [11:0] a, input logic [3:0] c,
                           input logic [31:0] p, input logic [15:0] s);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_code = c; tbl_ptr = p; tbl_size = s;
        mdl[int'(a)] = {c, p, s};
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] vlan, input logic [31:0] ip,
                        input logic [15:0] sp, input logic [15:0] dp,
                        input bit opts, input logic [31:0] hnd,
                        input logic [15:0] off, input logic [15:0] len,
                        input string req, input bit coll, input logic [3:0] ccode);
        int          idx;
        logic [51:0] ent;
        bit          fwd;
        idx = int'(vlan[11:0]);
        ent = mdl.exists(idx) ? mdl[idx] : 52'd0;
        fwd = !opts && (ent[51:48] != 4'd0);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_vlan = vlan; in_src_ip = ip; in_sport = sp;
        in_dport = dp; in_ip_opts = opts; in_handle = hnd;
        in_offset = off; in_length = len;
        if (coll) begin
            tbl_we = 1'b1; tbl_addr = vlan[11:0]; tbl_code = ccode;
            tbl_ptr = 32'h0; tbl_size = 16'h0;
            mdl[idx] = {ccode, 32'h0, 16'h0};
        end
        if (fwd) begin
            exp_q.push_back({vlan[11:0], ent, ip, sp, dp, hnd, off, len});
            tag_q.push_back(req);
        end
        @(negedge clk);
        in_valid = 1'b0; tbl_we = 1'b0;
        chk(!out_valid && !in_ready, "R9", "lookup cycle out_valid/in_ready",
            {out_valid, in_ready}, 2'b00);
        @(negedge clk);
        chk(out_valid == fwd, req, "out_valid at due cycle", out_valid, fwd);
        if (!fwd && opts) e_dbad++;
        if (!fwd && !opts) e_dslice++;
        chk(cnt_drop_bad == e_dbad, "R5", "cnt_drop_bad", cnt_drop_bad, e_dbad);
        chk(cnt_drop_slice == e_dslice, "R4", "cnt_drop_slice", cnt_drop_slice, e_dslice);
    endtask

    // Monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (fwd_pend) begin
                chk(cnt_fwd == e_fwd, "R6", "cnt_fwd", cnt_fwd, e_fwd);
                fwd_pend = 0;
            end
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected record", out_handle, 0);
                end else begin
                    logic [191:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_slice, out_code, out_ptr, out_size, out_src_ip, out_sport,
                         out_dport, out_handle, out_offset, out_length} == e, t,
                        "record fields",
                        {out_slice, out_code, out_ptr, out_size, out_src_ip, out_sport,
                         out_dport, out_handle, out_offset, out_length}, e);
                end
                e_fwd++;
                fwd_pend = 1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_vlan = '0; in_src_ip = '0;
        in_sport = '0; in_dport = '0; in_ip_opts = 1'b0; in_handle = '0;
        in_offset = '0; in_length = '0; tbl_we = 1'b0; tbl_addr = '0;
        tbl_code = '0; tbl_ptr = '0; tbl_size = '0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(cnt_fwd == 0 && cnt_drop_slice == 0 && cnt_drop_bad == 0, "R1",
            "counters", {cnt_fwd, cnt_drop_slice, cnt_drop_bad}, 0);

        host_wr(12'h0AA, 4'd1, 32'h1000_0040, 16'd64);
        host_wr(12'h7FF, 4'd0, 32'h0, 16'd0);
        host_wr(12'h123, 4'd9, 32'hCAFE_0000, 16'd128);
        host_wr(12'h050, 4'd3, 32'h0000_5000, 16'd32);
        host_wr(12'h000, 4'd15, 32'hFFFF_FFF0, 16'hFFFF);

        // R3 basic forwards, several patterns
        send(16'h00AA, 32'h0A00_0001, 16'd5000, 16'd6000, 0, 32'h11, 16'd42, 16'd100, "R3", 0, 0);
        send(16'h0123, 32'hC0A8_0102, 16'h1234, 16'hFFFF, 0, 32'h22, 16'd0, 16'hFFFF, "R3", 0, 0);
        send(16'h0000, 32'hFFFF_FFFF, 16'd0, 16'd1, 0, 32'hDEAD_BEEF, 16'hFFFF, 16'd1, "R3", 0, 0);
        // R2 high bits ignored
        send(16'hF0AA, 32'h0A00_0009, 16'd7, 16'd8, 0, 32'h33, 16'd10, 16'd20, "R2", 0, 0);
        // R4 disabled slice, and unwritten-to-disabled
        send(16'h07FF, 32'h0A00_0002, 16'd1, 16'd2, 0, 32'h44, 16'd0, 16'd0, "R4", 0, 0);
        // R5 ip options on enabled slice, then on disabled slice (priority)
        send(16'h00AA, 32'h0A00_0003, 16'd1, 16'd2, 1, 32'h55, 16'd0, 16'd0, "R5", 0, 0);
        send(16'h07FF, 32'h0A00_0004, 16'd1, 16'd2, 1, 32'h66, 16'd0, 16'd0, "R5", 0, 0);
        // R7 collision: old entry used, then new one applies
        send(16'h0050, 32'h0A00_0005, 16'd3, 16'd4, 0, 32'h77, 16'd8, 16'd9, "R7", 1, 4'd0);
        send(16'h0050, 32'h0A00_0006, 16'd3, 16'd4, 0, 32'h88, 16'd8, 16'd9, "R7", 0, 0);
        // R8 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        send(16'h0123, 32'h0A00_0007, 16'd11, 16'd12, 0, 32'h99, 16'd1, 16'd2, "R8", 0, 0);
        repeat (4) @(negedge clk);
        chk(out_valid && !in_ready, "R8", "held valid, input stalled",
            {out_valid, in_ready}, 2'b10);
        chk(out_handle == 32'h99, "R8", "held handle", out_handle, 32'h99);
        chk(cnt_fwd == e_fwd, "R6", "no count while stalled", cnt_fwd, e_fwd);
        out_ready = 1'b1;
        send(16'h00AA, 32'h0A00_0008, 16'd13, 16'd14, 0, 32'hAA, 16'd3, 16'd4, "R3", 0, 0);

        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "records outstanding", exp_q.size(), 0);
        chk(cnt_fwd == e_fwd, "R6", "final cnt_fwd", cnt_fwd, e_fwd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule